// File: doc/BRIEF.md
# Overcurrent Blanking Guard

This block decides whether a digital overcurrent comparator result is a real fault or switching noise. It watches the high-side switch-on signal and counts the cycles since the switch turned on. The comparator is ignored until a blanking window has passed. The window length depends on the operating mode, and it restarts each time the switch turns on.

The consequence of a trip also depends on the mode. In full-run mode a qualified trip latches a fault that holds both external gates off. The latch stays set until the controller goes straight from the off state back to full run, and that return raises a re-soft-start request. In suspend mode a qualified trip only ends conduction for the rest of the current switching period, and the next cycle-start pulse releases it. The latched fault also pulls the power-good qualification low.

Top module: `oc_blank_guard`

## Requirements
- R1: The 2-bit mode input encodes 00 as off, 01 as suspend and 10 as full run. The code 11 is treated exactly like off. While reset is held, faultLatched, cycleKill and softStartReq are 0.
- R2: In full run, a high comparator has no effect while hsOn is low.
- R3: In full run, the comparator is ignored during on-cycles 0 to RUN_BLANK-1 of each high-side on-time (default 63 cycles, about 500 ns at 125 MHz). A qualified trip at on-cycle index RUN_BLANK or later sets faultLatched at the next clock edge.
- R4: Once set, faultLatched stays high through suspend, further trips, and a return to full run from suspend. It clears only at the edge that ends the first full-run cycle entered directly from off (00 or 11).
- R5: softStartReq is a one-cycle pulse. It is visible in the cycle after the first full-run cycle that directly follows an off cycle.
- R6: pgQual equals pgRaw while no fault is latched and is 0 while faultLatched is 1.
- R7: In suspend, a qualified trip at on-cycle index SUSP_BLANK or later (default 50, 400 ns) raises cycleKill from the next cycle. cycleKill then holds until the edge at which cycleStart is sampled high. A trip sampled in the same cycle as cycleStart still sets it.
- R8: faultLatched is never set by a trip in suspend or off. cycleKill is 0 in every cycle that follows a cycle not in suspend.
- R9: A comparator that is high at any point during blanking stays masked until it goes low, even if it is still high when blanking ends. A new assertion after blanking does trip.
- R10: The blanking count restarts on every rising edge of hsOn, so a single low cycle starts a fresh blanking window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Operating mode code (see R1) |
| hsOn | input | 1 | High-side switch is being driven on |
| cycleStart | input | 1 | One-cycle pulse at the start of each switching period |
| ocTrip | input | 1 | Digital overcurrent comparator output |
| pgRaw | input | 1 | Power-good from the regulation monitors |
| faultLatched | output | 1 | Sticky full-run fault; both gates must be held off |
| cycleKill | output | 1 | End conduction for the rest of this suspend period |
| softStartReq | output | 1 | Pulse requesting a fresh soft-start |
| pgQual | output | 1 | Power-good qualified by the latched fault |

## Verification
The bound checker watches several properties on every cycle. A latched fault may drop only together with a soft-start pulse, and that pulse never lasts two cycles. Power-good is low under a fault. A fault rises only after a full-run cycle with the switch on and the comparator high, past the run blanking count. cycleKill never follows a non-suspend cycle, and it rises only after the suspend blanking count. The bench scenarios cover the behaviour that depends on history: a comparator still high when blanking ends, a window restarted by a one-cycle dip in hsOn, a latch that survives a suspend-to-run return but clears on off-to-run, and a trip that coincides with cycleStart.

// File: rtl/ocg_pkg.sv
`timescale 1ns/1ps
package ocg_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_SUSP = 2'b01,
    MODE_RUN  = 2'b10,
    MODE_RSVD = 2'b11
  } ocgMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic arm;      // trips may be qualified this cycle
    logic suspSel;  // use the suspend blanking length
  } ocgStrobe_t;

endpackage

// File: rtl/ocg_datapath.sv
`timescale 1ns/1ps
module ocg_datapath
  import ocg_pkg::*;
#(
  parameter int RUN_BLANK  = 63,
  parameter int SUSP_BLANK = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ocgStrobe_t strobe,
  input  logic       hsOn,
  input  logic       ocTrip,
  output logic       tripValid
);

  localparam int MAX_BLANK = (RUN_BLANK > SUSP_BLANK) ? RUN_BLANK : SUSP_BLANK;
  localparam int CW        = $clog2(MAX_BLANK + 1);

  logic [CW-1:0] onCnt;
  logic [CW-1:0] blankLimit;
  logic          maskHold;
  logic          inBlank;
  logic          inWindow;

  always_comb begin
    blankLimit = strobe.suspSel ? CW'(SUSP_BLANK) : CW'(RUN_BLANK);
    inBlank    = hsOn && (onCnt < blankLimit);
    inWindow   = hsOn && !inBlank;
    tripValid  = strobe.arm && inWindow && ocTrip && !maskHold;
  end

  // onCnt equals the on-cycle index, saturating at the active limit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      onCnt    <= '0;
      maskHold <= 1'b0;
    end else if (!hsOn) begin
      onCnt    <= '0;
      maskHold <= 1'b0;
    end else begin
      if (onCnt < blankLimit) onCnt <= onCnt + CW'(1);
      // a comparator seen during blanking stays masked until it drops
      maskHold <= ocTrip && (inBlank || maskHold);
    end
  end

endmodule

// File: rtl/ocg_control.sv
`timescale 1ns/1ps
module ocg_control
  import ocg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] modeIn,
  input  logic       cycleStart,
  input  logic       tripValid,
  output ocgStrobe_t strobe,
  output logic       faultQ,
  output logic       killQ,
  output logic       ssReqQ
);

  ocgMode_e modeNow;
  ocgMode_e modeQ;
  logic     isRun;
  logic     isSusp;
  logic     wasOff;
  logic     offToRun;

  always_comb begin
    modeNow        = ocgMode_e'(modeIn);
    isRun          = (modeNow == MODE_RUN);
    isSusp         = (modeNow == MODE_SUSP);
    wasOff         = (modeQ == MODE_OFF) || (modeQ == MODE_RSVD);
    offToRun       = wasOff && isRun;
    strobe.arm     = (isRun && !faultQ) || isSusp;
    strobe.suspSel = isSusp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ  <= MODE_OFF;
      faultQ <= 1'b0;
      killQ  <= 1'b0;
      ssReqQ <= 1'b0;
    end else begin
      modeQ  <= modeNow;
      ssReqQ <= offToRun;
      if (offToRun)                faultQ <= 1'b0;
      else if (isRun && tripValid) faultQ <= 1'b1;
      killQ  <= isSusp && (tripValid || (killQ && !cycleStart));
    end
  end

endmodule

// File: rtl/oc_blank_guard.sv
`timescale 1ns/1ps
module oc_blank_guard
  import ocg_pkg::*;
#(
  parameter int RUN_BLANK  = 63,
  parameter int SUSP_BLANK = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       hsOn,
  input  logic       cycleStart,
  input  logic       ocTrip,
  input  logic       pgRaw,
  output logic       faultLatched,
  output logic       cycleKill,
  output logic       softStartReq,
  output logic       pgQual
);

  ocgStrobe_t strobe;
  logic       tripValid;

  ocg_control u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .modeIn     (mode),
    .cycleStart (cycleStart),
    .tripValid  (tripValid),
    .strobe     (strobe),
    .faultQ     (faultLatched),
    .killQ      (cycleKill),
    .ssReqQ     (softStartReq)
  );

  ocg_datapath #(
    .RUN_BLANK  (RUN_BLANK),
    .SUSP_BLANK (SUSP_BLANK)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .hsOn      (hsOn),
    .ocTrip    (ocTrip),
    .tripValid (tripValid)
  );

  assign pgQual = pgRaw && !faultLatched;

endmodule

// File: rtl/oc_blank_guard_chk.sv
`timescale 1ns/1ps
module oc_blank_guard_chk #(
  parameter int RUN_BLANK  = 63,
  parameter int SUSP_BLANK = 50
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       hsOn,
  input logic       ocTrip,
  input logic       pgRaw,
  input logic       faultLatched,
  input logic       cycleKill,
  input logic       softStartReq,
  input logic       pgQual
);

  logic [15:0] onIdx;
  always_ff @(posedge clk) begin
    if (!rst_n || !hsOn) onIdx <= '0;
    else if (onIdx != 16'hFFFF) onIdx <= onIdx + 16'd1;
  end

  // R4: a latched fault only drops together with a soft-start pulse
  a_r4_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    faultLatched |=> (faultLatched || softStartReq));

  // R5: soft-start request lasts one cycle
  a_r5_ss_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    softStartReq |=> !softStartReq);

  // R6: fault forces power-good low
  a_r6_pg_low: assert property (@(posedge clk) disable iff (!rst_n)
    faultLatched |-> !pgQual);

  a_r6_pg_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !faultLatched |-> (pgQual == pgRaw));

  // R2 / R8: fault rises only after a full-run, switch-on, comparator-high cycle
  a_r2_fault_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(faultLatched) |-> ($past(mode) == 2'b10) && $past(hsOn) && $past(ocTrip));

  // R3: fault rises only after the run blanking count
  a_r3_run_blank: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(faultLatched) |-> ($past(onIdx) >= 16'(RUN_BLANK)));

  // R7: cycle kill rises only after the suspend blanking count
  a_r7_susp_blank: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cycleKill) |-> ($past(onIdx) >= 16'(SUSP_BLANK)) && $past(ocTrip));

  // R8: no cycle kill after a non-suspend cycle
  a_r8_kill_mode: assert property (@(posedge clk) disable iff (!rst_n)
    cycleKill |-> ($past(mode) == 2'b01));

endmodule

bind oc_blank_guard oc_blank_guard_chk #(
  .RUN_BLANK  (RUN_BLANK),
  .SUSP_BLANK (SUSP_BLANK)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode         (mode),
  .hsOn         (hsOn),
  .ocTrip       (ocTrip),
  .pgRaw        (pgRaw),
  .faultLatched (faultLatched),
  .cycleKill    (cycleKill),
  .softStartReq (softStartReq),
  .pgQual       (pgQual)
);

// File: tb/oc_blank_guard_bench.sv
`timescale 1ns/1ps
module oc_blank_guard_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       hsOn = 1'b0;
  logic       cycleStart = 1'b0;
  logic       ocTrip = 1'b0;
  logic       pgRaw = 1'b1;
  logic       faultLatched, cycleKill, softStartReq, pgQual;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  oc_blank_guard u_oc_blank_guard (
    .clk(clk), .rst_n(rst_n), .mode(mode), .hsOn(hsOn),
    .cycleStart(cycleStart), .ocTrip(ocTrip), .pgRaw(pgRaw),
    .faultLatched(faultLatched), .cycleKill(cycleKill),
    .softStartReq(softStartReq), .pgQual(pgQual)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  typedef struct packed {
    logic [1:0] m;
    logic [7:0] len;
    logic [7:0] ts;   // first on-cycle with comparator high, FF = never
    logic       ef;
    logic       ek;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'b10, 8'd80,  8'd63,  1'b1, 1'b0},  // R3 first open cycle
    '{2'b10, 8'd80,  8'd62,  1'b0, 1'b0},  // R9 high across blanking end
    '{2'b10, 8'd63,  8'd63,  1'b0, 1'b0},  // R3 on-time too short
    '{2'b10, 8'd100, 8'd99,  1'b1, 1'b0},  // R3 late trip
    '{2'b01, 8'd60,  8'd50,  1'b0, 1'b1},  // R7 first open cycle
    '{2'b01, 8'd60,  8'd49,  1'b0, 1'b0},  // R9 suspend masked
    '{2'b01, 8'd80,  8'd63,  1'b0, 1'b1},  // R8 suspend never latches
    '{2'b00, 8'd80,  8'd70,  1'b0, 1'b0},  // R8 off ignored
    '{2'b11, 8'd80,  8'd70,  1'b0, 1'b0},  // R1 reserved as off
    '{2'b10, 8'd20,  8'd0,   1'b0, 1'b0}   // R3 inside blanking
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic goRun();
    mode = 2'b00; step();
    mode = 2'b10; step();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    wait (cyc >= 20000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    // reset state (R1, R6)
    step(); step(); step();
    chk("R1 reset fault", int'(faultLatched), 0);
    chk("R1 reset kill", int'(cycleKill), 0);
    chk("R1 reset softstart", int'(softStartReq), 0);
    chk("R6 reset pgQual", int'(pgQual), 1);
    rst_n = 1'b1;
    step();

    // vector table
    for (int v = 0; v < NV; v++) begin
      mode = 2'b00; hsOn = 1'b0; ocTrip = 1'b0; step();
      mode = 2'b10; step();
      mode = VEC[v].m; cycleStart = 1'b1; step();
      cycleStart = 1'b0;
      for (int i = 0; i < int'(VEC[v].len); i++) begin
        hsOn   = 1'b1;
        ocTrip = (VEC[v].ts != 8'hFF) && (i >= int'(VEC[v].ts));
        step();
      end
      hsOn = 1'b0; ocTrip = 1'b0; step();
      chk($sformatf("R3 R8 R9 vec%0d fault", v), int'(faultLatched), int'(VEC[v].ef));
      chk($sformatf("R7 R8 vec%0d kill", v), int'(cycleKill), int'(VEC[v].ek));
    end

    // R1 / R5: reserved code acts as off for the soft-start pulse
    mode = 2'b11; step();
    mode = 2'b10; step();
    chk("R1 R5 reserved->run softstart", int'(softStartReq), 1);
    step();
    chk("R5 softstart one cycle", int'(softStartReq), 0);

    // R4 / R6: sticky fault
    goRun();
    for (int i = 0; i < 70; i++) begin hsOn = 1'b1; ocTrip = (i >= 63); step(); end
    hsOn = 1'b0; ocTrip = 1'b0; step();
    chk("R3 directed trip", int'(faultLatched), 1);
    chk("R6 pgQual under fault", int'(pgQual), 0);
    mode = 2'b01; step(); step(); step();
    chk("R4 held in suspend", int'(faultLatched), 1);
    mode = 2'b10; step(); step();
    chk("R4 held after suspend->run", int'(faultLatched), 1);
    chk("R5 no softstart from suspend", int'(softStartReq), 0);
    mode = 2'b00; step();
    chk("R4 held while off", int'(faultLatched), 1);
    mode = 2'b10; step();
    chk("R4 cleared by off->run", int'(faultLatched), 0);
    chk("R5 softstart on clear", int'(softStartReq), 1);
    chk("R6 pgQual restored", int'(pgQual), 1);
    step();
    chk("R5 softstart dropped", int'(softStartReq), 0);

    // R7: kill held until cycleStart
    mode = 2'b00; step();
    mode = 2'b01; step();
    for (int i = 0; i < 55; i++) begin hsOn = 1'b1; ocTrip = (i >= 52); step(); end
    hsOn = 1'b0; ocTrip = 1'b0; step();
    chk("R7 kill set", int'(cycleKill), 1);
    step(); step(); step();
    chk("R7 kill held", int'(cycleKill), 1);
    cycleStart = 1'b1; step();
    cycleStart = 1'b0;
    chk("R7 kill cleared by cycleStart", int'(cycleKill), 0);
    for (int i = 0; i < 55; i++) begin
      hsOn = 1'b1; ocTrip = (i == 54); cycleStart = (i == 54); step();
    end
    hsOn = 1'b0; ocTrip = 1'b0; cycleStart = 1'b0; step();
    chk("R7 trip wins over cycleStart", int'(cycleKill), 1);
    mode = 2'b10; step();
    chk("R8 kill dropped outside suspend", int'(cycleKill), 0);

    // R10: one low cycle restarts blanking
    goRun();
    for (int i = 0; i < 40; i++) begin hsOn = 1'b1; ocTrip = 1'b0; step(); end
    hsOn = 1'b0; step();
    for (int i = 0; i < 40; i++) begin hsOn = 1'b1; ocTrip = (i >= 30); step(); end
    hsOn = 1'b0; ocTrip = 1'b0; step();
    chk("R10 blanking restarted", int'(faultLatched), 0);

    // R9: masked pulse, then a fresh one trips
    goRun();
    for (int i = 0; i < 80; i++) begin
      hsOn = 1'b1;
      ocTrip = ((i >= 60) && (i <= 65)) || ((i >= 70) && (i <= 75));
      step();
    end
    hsOn = 1'b0; ocTrip = 1'b0; step();
    chk("R9 fresh assertion trips", int'(faultLatched), 1);

    // R2: comparator with switch off
    goRun();
    hsOn = 1'b0;
    for (int i = 0; i < 100; i++) begin ocTrip = 1'b1; step(); end
    ocTrip = 1'b0; step();
    chk("R2 ignored with switch off", int'(faultLatched), 0);

    summary();
    $finish;
  end

endmodule